// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Per-Entry Page Size

This block is a fully associative address translation cache of 64 slots that only software fills. Each slot maps one virtual page to one physical page. Each slot has its own page size, from 1 KiB to 16 MiB, and its own context tag. Slots of every size are compared against the incoming address in parallel. The virtual-address bits below each slot's page size pass straight through to the physical address.

Software places a translation with an explicit slot index on the write port. A slot can be marked pinned. Pinned slots survive a global invalidate and are never offered as the replacement victim. The block also provides a victim index that steps round-robin over the unpinned slots, which miss-handler software can use when it picks a slot to overwrite. A lookup that finds no match produces a one-cycle miss pulse for the exception logic. There is no hardware table walk.

Top module: `soft_tlb`

## Requirements
- R1: A lookup presented with `lk_en` high gives its result on `lk_hit`, `lk_pa` and `lk_attr` exactly one clock later. On a hit, `lk_pa` is the slot's physical page joined with the virtual-address bits below the page size. The hit flag and the miss pulse stay low in every cycle that follows a clock without `lk_en`.
- R2: Size code s (3 bits) selects a page of 2^(10+2s) bytes: 0=1K, 1=4K, 2=16K, 3=64K, 4=256K, 5=1M, 6=4M, 7=16M. Virtual-address bits below 10+2s are ignored in the compare and copied to the physical address. An address one page past the base misses.
- R3: A slot whose context tag is 0 matches under any current context. A slot with a nonzero tag matches only when `lk_ctx` equals that tag.
- R4: A lookup that matches no valid slot gives `lk_hit`=0 and `lk_miss`=1 for one cycle. `lk_miss` and `lk_hit` are never high together.
- R5: When several valid slots match, the lowest-index slot supplies `lk_pa` and `lk_attr`, and `lk_multi` is high. `lk_multi` is low when exactly one slot matches.
- R6: A write is visible to lookups presented from the next cycle on. A lookup presented in the same cycle as the write sees the old contents.
- R7: `inv_all` clears the valid bit of every slot that is not pinned. Pinned slots keep translating.
- R8: `clr_pin` releases every pin without changing the valid bits. After that, `inv_all` clears the formerly pinned slots as well.
- R9: `victim_idx` is 0 after reset. It never names a pinned slot while at least one slot is unpinned. It moves to the next unpinned slot in ascending order, wrapping at the top, on the clock of any write to the slot it currently names. It holds on every other clock.
- R10: After reset every slot is invalid and unpinned, and `lk_hit`, `lk_miss` and `lk_multi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 22 | Virtual address bits 31:10 |
| wr_ctx | input | 8 | Context tag (0 = global) |
| wr_rpn | input | 22 | Physical address bits 31:10 |
| wr_size | input | 3 | Page-size code |
| wr_valid | input | 1 | Valid bit stored in the slot |
| wr_attr | input | 6 | Access and attribute bits |
| wr_pin | input | 1 | Pin the slot against replacement and invalidate |
| inv_all | input | 1 | Invalidate every unpinned slot |
| clr_pin | input | 1 | Release all pins |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_ctx | input | 8 | Current context |
| lk_hit | output | 1 | Registered hit |
| lk_miss | output | 1 | One-cycle miss pulse |
| lk_multi | output | 1 | More than one slot matched |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 6 | Attribute bits of the winning slot |
| victim_idx | output | 6 | Round-robin replacement candidate |

## Verification
On every cycle, the assertions check that hit and miss exclude each other, that no result appears without a lookup the cycle before, that the multi-match flag only comes with a hit, that the victim index avoids pinned slots, and that an invalidate leaves no unpinned slot valid. Only the bench scenarios can show that the translated addresses are correct. Those scenarios cover every page size at page edges, context and global matching, lowest-index priority, the old-contents view during a same-cycle write, pin release, and the victim sequence as it wraps around pinned slots.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
    localparam int ADDR_W   = 32;
    localparam int MIN_PG_W = 10;
    localparam int PN_W     = ADDR_W - MIN_PG_W;
    localparam int CTX_W    = 8;
    localparam int ATTR_W   = 6;
    localparam int SZ_W     = 3;

    typedef struct packed {
        logic              valid;
        logic [SZ_W-1:0]   size;
        logic [CTX_W-1:0]  ctx;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   rpn;
        logic [ATTR_W-1:0] attr;
    } slot_t;

    // Ones over the page-number bits that take part in the compare
    function automatic logic [PN_W-1:0] keep_mask(input logic [SZ_W-1:0] sz);
        logic [PN_W-1:0] m;
        m = '1;
        m = m << (32'(sz) * 2);
        return m;
    endfunction
endpackage

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic             wr_pin,
    input  logic             inv_all,
    input  logic             clr_pin,
    output slot_t            slots [ENTRIES],
    output logic [ENTRIES-1:0] pin_q,
    output logic [ENTRIES-1:0] pin_nxt
);
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) pin_nxt[i] = wr_pin;
            else if (clr_pin)                 pin_nxt[i] = 1'b0;
            else                              pin_nxt[i] = pin_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
            pin_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all && !pin_q[i]) slots[i].valid <= 1'b0;
                if (wr_en && wr_idx == IDX_W'(i)) slots[i] <= wr_slot;
            end
            pin_q <= pin_nxt;
        end
    end
endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  slot_t              slots [ENTRIES],
    input  logic [ADDR_W-1:0]  va,
    input  logic [CTX_W-1:0]   ctx,
    output logic               hit,
    output logic               multi,
    output logic [ADDR_W-1:0]  pa,
    output logic [ATTR_W-1:0]  attr
);
    logic [ENTRIES-1:0] hv;
    logic [IDX_W-1:0]   sel;
    logic [PN_W-1:0]    va_pn;
    logic [PN_W-1:0]    km;

    assign va_pn = va[ADDR_W-1:MIN_PG_W];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [PN_W-1:0] m;
        assign m = keep_mask(slots[i].size);
        assign hv[i] = slots[i].valid
                    && (((slots[i].vpn ^ va_pn) & m) == '0)
                    && (slots[i].ctx == '0 || slots[i].ctx == ctx);
    end

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (hv[i]) sel = IDX_W'(i);
    end

    assign hit   = |hv;
    assign multi = (hv & (hv - 1'b1)) != '0;
    assign km    = keep_mask(slots[sel].size);
    assign pa    = {(slots[sel].rpn & km) | (va_pn & ~km), va[MIN_PG_W-1:0]};
    assign attr  = slots[sel].attr;
endmodule

// File: rtl/soft_tlb_victim.sv
module soft_tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRIES-1:0] pin_nxt,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] nxt;
    logic [IDX_W-1:0] cand;
    logic             step;

    always_comb begin
        nxt  = victim;
        cand = '0;
        for (int k = ENTRIES - 1; k >= 1; k--) begin
            cand = IDX_W'((int'(victim) + k) % ENTRIES);
            if (!pin_nxt[cand]) nxt = cand;
        end
    end

    assign step = (wr_en && wr_idx == victim) || pin_nxt[victim];

    always_ff @(posedge clk) begin
        if (rst)       victim <= '0;
        else if (step) victim <= nxt;
    end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PN_W-1:0]   wr_rpn,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic              wr_valid,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_pin,
    input  logic              inv_all,
    input  logic              clr_pin,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic [ADDR_W-1:0] lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    output logic [IDX_W-1:0]  victim_idx
);
    slot_t              slots [ENTRIES];
    slot_t              wr_slot;
    logic [ENTRIES-1:0] pin_q;
    logic [ENTRIES-1:0] pin_nxt;
    logic [ENTRIES-1:0] valid_v;
    logic               m_hit, m_multi;
    logic [ADDR_W-1:0]  m_pa;
    logic [ATTR_W-1:0]  m_attr;

    assign wr_slot = '{valid: wr_valid, size: wr_size, ctx: wr_ctx,
                       vpn: wr_vpn, rpn: wr_rpn, attr: wr_attr};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
        assign valid_v[i] = slots[i].valid;
    end

    soft_tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_slot(wr_slot), .wr_pin(wr_pin), .inv_all(inv_all),
        .clr_pin(clr_pin), .slots(slots), .pin_q(pin_q), .pin_nxt(pin_nxt)
    );

    soft_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .slots(slots), .va(lk_va), .ctx(lk_ctx), .hit(m_hit),
        .multi(m_multi), .pa(m_pa), .attr(m_attr)
    );

    soft_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .pin_nxt(pin_nxt), .victim(victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_multi <= 1'b0;
            lk_pa    <= '0;
            lk_attr  <= '0;
        end else begin
            lk_hit   <= lk_en && m_hit;
            lk_miss  <= lk_en && !m_hit;
            lk_multi <= lk_en && m_multi;
            if (lk_en) begin
                lk_pa   <= m_pa;
                lk_attr <= m_attr;
            end
        end
    end
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_en,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_multi,
    input logic               wr_en,
    input logic               inv_all,
    input logic               clr_pin,
    input logic [IDX_W-1:0]   victim_idx,
    input logic [ENTRIES-1:0] pin_q,
    input logic [ENTRIES-1:0] valid_v
);
    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    // R1
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> !lk_hit && !lk_miss);

    // R5
    multi_with_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);

    // R9
    victim_unpinned_chk: assert property (@(posedge clk) disable iff (rst)
        (~pin_q != '0) |-> !pin_q[victim_idx]);

    // R7
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !wr_en && !clr_pin) |=> ((valid_v & ~pin_q) == '0));
endmodule

bind soft_tlb soft_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_multi(lk_multi), .wr_en(wr_en),
    .inv_all(inv_all), .clr_pin(clr_pin), .victim_idx(victim_idx),
    .pin_q(pin_q), .valid_v(valid_v)
);

// File: tb/sim_soft_tlb.sv
module sim_soft_tlb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_ctx = '0;
    logic [21:0] wr_rpn = '0;
    logic [2:0]  wr_size = '0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_attr = '0;
    logic        wr_pin = 1'b0;
    logic        inv_all = 1'b0;
    logic        clr_pin = 1'b0;
    logic        lk_en = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_ctx = '0;
    logic        lk_hit, lk_miss, lk_multi;
    logic [31:0] lk_pa;
    logic [5:0]  lk_attr;
    logic [5:0]  victim_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    soft_tlb u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xlate(input logic [31:0] va, input logic [31:0] base, input int sz);
        logic [31:0] m;
        m = (32'h1 << (10 + 2 * sz)) - 1;
        return (base & ~m) | (va & m);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; inv_all = 0; clr_pin = 0; lk_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] va, input logic [7:0] ctx,
                      input logic [31:0] pa, input int sz, input logic [5:0] at, input bit pin);
        @(negedge clk);
        wr_en = 1; wr_idx = 6'(idx); wr_vpn = va[31:10]; wr_ctx = ctx;
        wr_rpn = pa[31:10]; wr_size = 3'(sz); wr_valid = 1; wr_attr = at; wr_pin = pin;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] ctx);
        @(negedge clk);
        lk_en = 1; lk_va = va; lk_ctx = ctx;
        @(negedge clk);
        lk_en = 0;
    endtask

    task automatic pulse_ctl(input bit inv, input bit clr);
        @(negedge clk);
        inv_all = inv; clr_pin = clr;
        @(negedge clk);
        inv_all = 0; clr_pin = 0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R10 hit", 32'(lk_hit), 0);
        chk("R10 miss", 32'(lk_miss), 0);
        chk("R10 multi", 32'(lk_multi), 0);
        chk("R9 victim", 32'(victim_idx), 0);
        look(32'h1234_5678, 8'd0);
        chk("R10 empty hit", 32'(lk_hit), 0);
        chk("R4 miss pulse", 32'(lk_miss), 1);
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(lk_miss), 0);
    endtask

    task automatic t_basic();
        wr(5, 32'h1234_5000, 8'd3, 32'h8000_0000, 1, 6'h2A, 0);
        look(32'h1234_5ABC, 8'd3);
        chk("R1 hit", 32'(lk_hit), 1);
        chk("R1 pa", lk_pa, 32'h8000_0ABC);
        chk("R1 attr", 32'(lk_attr), 32'h2A);
        chk("R5 single no multi", 32'(lk_multi), 0);
        @(negedge clk);
        chk("R1 no req no hit", 32'(lk_hit), 0);
    endtask

    task automatic t_sizes();
        for (int s = 0; s < 8; s++) begin
            logic [31:0] va;
            logic [31:0] pgm;
            pgm = (32'h1 << (10 + 2 * s)) - 1;
            wr(10, 32'h4000_0000, 8'd0, 32'hA000_0000, s, 6'(s), 0);
            va = 32'h4000_0000 | (32'h5A5A_5A5A & pgm);
            look(va, 8'd1);
            chk($sformatf("R2 size %0d hit", s), 32'(lk_hit), 1);
            chk($sformatf("R2 size %0d pa", s), lk_pa, xlate(va, 32'hA000_0000, s));
            look(32'h4000_0000 + pgm + 1, 8'd1);
            chk($sformatf("R2 size %0d past page", s), 32'(lk_hit), 0);
        end
    endtask

    task automatic t_ctx();
        wr(12, 32'h5000_0000, 8'd7, 32'hB000_0000, 1, 6'h01, 0);
        wr(13, 32'h5100_0000, 8'd0, 32'hC000_0000, 1, 6'h02, 0);
        look(32'h5000_0010, 8'd7);
        chk("R3 own ctx", 32'(lk_hit), 1);
        look(32'h5000_0010, 8'd8);
        chk("R3 other ctx", 32'(lk_hit), 0);
        look(32'h5100_0020, 8'd9);
        chk("R3 global hit", 32'(lk_hit), 1);
        chk("R3 global pa", lk_pa, 32'hC000_0020);
    endtask

    task automatic t_multi();
        wr(30, 32'h6000_0000, 8'd0, 32'hD000_0000, 2, 6'h30, 0);
        wr(20, 32'h6000_0000, 8'd0, 32'hE000_0000, 1, 6'h20, 0);
        look(32'h6000_0123, 8'd0);
        chk("R5 hit", 32'(lk_hit), 1);
        chk("R5 multi", 32'(lk_multi), 1);
        chk("R5 lowest pa", lk_pa, 32'hE000_0123);
        chk("R5 lowest attr", 32'(lk_attr), 32'h20);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1; wr_idx = 6'd40; wr_vpn = 22'(32'h7000_0000 >> 10); wr_ctx = 0;
        wr_rpn = 22'(32'h9000_0000 >> 10); wr_size = 0; wr_valid = 1; wr_attr = 0; wr_pin = 0;
        lk_en = 1; lk_va = 32'h7000_0044; lk_ctx = 0;
        @(negedge clk);
        wr_en = 0; lk_en = 0;
        chk("R6 old contents", 32'(lk_hit), 0);
        look(32'h7000_0044, 8'd0);
        chk("R6 new contents", 32'(lk_hit), 1);
        chk("R6 new pa", lk_pa, 32'h9000_0044);
    endtask

    task automatic t_inval();
        wr(0, 32'h0000_0000, 8'd0, 32'h2000_0000, 7, 6'h3F, 1);
        pulse_ctl(1, 0);
        look(32'h1234_5678, 8'd3);
        chk("R7 unpinned cleared", 32'(lk_hit), 0);
        look(32'h0012_3456, 8'd1);
        chk("R7 pinned kept", 32'(lk_hit), 1);
        chk("R7 pinned pa", lk_pa, 32'h2012_3456);
        pulse_ctl(0, 1);
        look(32'h0012_3456, 8'd1);
        chk("R8 release keeps valid", 32'(lk_hit), 1);
        pulse_ctl(1, 0);
        look(32'h0012_3456, 8'd1);
        chk("R8 released cleared", 32'(lk_hit), 0);
    endtask

    task automatic t_victim();
        do_reset();
        wr(0, 32'h0000_0000, 8'd0, 32'h0, 7, 0, 1);
        chk("R9 skip pinned 0", 32'(victim_idx), 1);
        wr(1, 32'h0100_0000, 8'd0, 32'h0, 7, 0, 1);
        chk("R9 skip pinned 1", 32'(victim_idx), 2);
        wr(2, 32'h0800_0000, 8'd0, 32'h0, 0, 0, 0);
        chk("R9 step", 32'(victim_idx), 3);
        wr(10, 32'h0900_0000, 8'd0, 32'h0, 0, 0, 0);
        chk("R9 hold on other write", 32'(victim_idx), 3);
        for (int i = 3; i < 64; i++) wr(i, 32'h0A00_0000, 8'd0, 32'h0, 0, 0, 0);
        chk("R9 wrap past pins", 32'(victim_idx), 2);
        pulse_ctl(0, 1);
        chk("R9 hold on release", 32'(victim_idx), 2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sizes();
        t_ctx();
        t_multi();
        t_same_cycle();
        t_inval();
        t_victim();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule